// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block sits behind a test access port and lets a debug host read and write a small bank of 32-bit registers one data-register scan at a time. The TAP controller is outside the block and supplies the current instruction together with the capture, shift and update strobes. The host first selects chain 0 through a 5-bit chain-select scan. It then loads the register-access instruction and shifts 40-bit frames. Each frame carries a data word, a register address and a direction bit. One update issues exactly one register transaction.

Reads are pipelined across scans. The result of a read issued in one frame leaves the device in the data field of the next frame. A host that reads a register whose read has a side effect, such as a buffer data port, therefore ends the sequence with a read of a harmless address (address 0). That final read collects the pending result without consuming another entry.

The access sequencer runs as a small state machine. `ST_IDLE` waits for a capture with access selected; the capture is the transition idle-to-loaded. `ST_LOADED` holds while the frame shifts; an update takes the loaded-to-issue transition. `ST_ISSUE` lasts one clock, raises the register request and latches read data; it always takes the issue-to-idle transition. An update seen in `ST_IDLE` takes the idle-hold transition and stays there.

Top module: `scan_regport`

## Requirements
- R1: With instruction 0xC loaded and chain 0 selected, every shift clock moves the 40-bit frame one bit toward `tdo`, least-significant bit first. `tdi` enters at bit 39. Bits 0..31 are data, bits 32..38 the address and bit 39 the direction.
- R2: A capture in access mode loads bits 0..31 with the result of the most recent read and clears bits 32..39, so the first 32 bits shifted out are the previous read result and the last 8 are zero.
- R3: An update of a frame whose direction bit is 1 drives `reg_req` high for one cycle, starting one clock after the update edge, with `reg_wr`=1 and the frame's address and data.
- R4: An update of a frame whose direction bit is 0 issues a one-cycle request with `reg_wr`=0. The `reg_rdata` sampled in that cycle appears in the data field of the next access frame.
- R5: Each update preceded by an access capture issues exactly one request. An update with no access capture since the last transaction issues nothing. A side-effecting register is therefore read exactly once per read frame.
- R6: For an address at or above `NUM_REGS`, no request is issued. A read of such an address returns zero in the next frame.
- R7: With instruction 0x2, a 5-bit register shifts LSB first between `tdi` and `tdo`. Capture loads it with the current `chain_sel`, and update copies it to `chain_sel`.
- R8: When the instruction is neither 0xC nor 0x2, or when it is 0xC with a nonzero chain, the strobes issue no request and `tdo` stays 0.
- R9: After reset `chain_sel` is 0, no request is pending, the held read result is 0 and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| ir_value | input | IR_W | Instruction currently held by the TAP |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe, one bit per clock |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| chain_sel | output | CHAIN_W | Selected scan chain |
| reg_req | output | 1 | One-cycle register transaction request |
| reg_wr | output | 1 | 1 write, 0 read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Write data |
| reg_rdata | input | DATA_W | Read data, sampled in the request cycle |

## Verification
The bench builds the block with its defaults: 32-bit data, 7-bit address, 5-bit chain and nine implemented registers. With nine registers, in-range and out-of-range addresses can both be scanned within a handful of frames. The register model in the bench gives address 4 a read side effect, so the one-read-per-frame rule and the dummy final read can be observed. Chain values 3 and 0 exercise both the locked-out and the routed paths of the access frame.

// File: rtl/scan_regport_pkg.sv
package scan_regport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_ISSUE  = 2'd2
    } acc_state_e;
endpackage

// File: rtl/scan_dr_frame.sv
module scan_dr_frame #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              tdi,
    input  logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] f_data,
    output logic [ADDR_W-1:0] f_addr,
    output logic              f_dir,
    output logic              sout
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;

    logic [FRAME_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (cap_en) begin
            sr <= {1'b0, {ADDR_W{1'b0}}, hold};
        end else if (shift_en) begin
            sr <= {tdi, sr[FRAME_W-1:1]};
        end
    end

    assign f_data = sr[DATA_W-1:0];
    assign f_addr = sr[DATA_W+ADDR_W-1:DATA_W];
    assign f_dir  = sr[FRAME_W-1];
    assign sout   = sr[0];
endmodule

// File: rtl/scan_chain_sel.sv
module scan_chain_sel #(
    parameter int CHAIN_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic [CHAIN_W-1:0] chain,
    output logic               sout
);
    logic [CHAIN_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            chain <= '0;
        end else if (sel) begin
            if (capture_dr) begin
                sr <= chain;
            end else if (shift_dr) begin
                sr <= {tdi, sr[CHAIN_W-1:1]};
            end
            if (update_dr) begin
                chain <= sr;
            end
        end
    end

    assign sout = sr[0];
endmodule

// File: rtl/scan_access_fsm.sv
module scan_access_fsm
    import scan_regport_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              upd,
    input  logic              f_dir,
    input  logic              in_range,
    input  logic [DATA_W-1:0] rdata,
    output logic              req,
    output logic [DATA_W-1:0] hold
);
    acc_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cap) state_nx = ST_LOADED;
            ST_LOADED: if (upd) state_nx = ST_ISSUE;
            ST_ISSUE:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (state == ST_ISSUE && !f_dir) begin
            hold <= in_range ? rdata : '0;
        end
    end

    assign req = (state == ST_ISSUE) && in_range;
endmodule

// File: rtl/scan_regport.sv
module scan_regport
    import scan_regport_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 7,
    parameter int          CHAIN_W   = 5,
    parameter int          IR_W      = 4,
    parameter int          NUM_REGS  = 9,
    parameter logic [IR_W-1:0] IR_ACCESS = 4'hC,
    parameter logic [IR_W-1:0] IR_CHAIN  = 4'h2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IR_W-1:0]    ir_value,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    output logic [CHAIN_W-1:0] chain_sel,
    output logic               reg_req,
    output logic               reg_wr,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic [DATA_W-1:0]  reg_wdata,
    input  logic [DATA_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(NUM_REGS);

    logic              acc_ir, chain_ir, acc_sel;
    logic              frame_sout, chain_sout, f_dir, in_range;
    logic [DATA_W-1:0] hold, f_data;
    logic [ADDR_W-1:0] f_addr;

    assign acc_ir   = (ir_value == IR_ACCESS);
    assign chain_ir = (ir_value == IR_CHAIN);
    assign acc_sel  = acc_ir && (chain_sel == '0);
    assign in_range = ({1'b0, f_addr} < ADDR_LIMIT);

    scan_chain_sel #(.CHAIN_W(CHAIN_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .sel(chain_ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .chain(chain_sel), .sout(chain_sout)
    );

    scan_dr_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cap_en(capture_dr && acc_sel), .shift_en(shift_dr && acc_sel),
        .tdi(tdi), .hold(hold),
        .f_data(f_data), .f_addr(f_addr), .f_dir(f_dir), .sout(frame_sout)
    );

    scan_access_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cap(capture_dr && acc_sel), .upd(update_dr && acc_sel),
        .f_dir(f_dir), .in_range(in_range), .rdata(reg_rdata),
        .req(reg_req), .hold(hold)
    );

    assign reg_wr    = f_dir;
    assign reg_addr  = f_addr;
    assign reg_wdata = f_data;
    assign tdo       = acc_sel ? frame_sout : (chain_ir ? chain_sout : 1'b0);
endmodule

// File: rtl/scan_regport_chk.sv
module scan_regport_chk #(
    parameter int          ADDR_W    = 7,
    parameter int          CHAIN_W   = 5,
    parameter int          IR_W      = 4,
    parameter int          NUM_REGS  = 9,
    parameter logic [IR_W-1:0] IR_ACCESS = 4'hC
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IR_W-1:0]    ir_value,
    input logic               update_dr,
    input logic [CHAIN_W-1:0] chain_sel,
    input logic               reg_req,
    input logic [ADDR_W-1:0]  reg_addr
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> !reg_req); // R5
    AST_REQ_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> $past(update_dr)); // R3
    AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> ({1'b0, reg_addr} < (ADDR_W+1)'(NUM_REGS))); // R6
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(update_dr) |-> $stable(chain_sel)); // R7
    AST_REQ_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> $past(ir_value == IR_ACCESS && chain_sel == '0)); // R8
endmodule

bind scan_regport scan_regport_chk #(
    .ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W), .IR_W(IR_W),
    .NUM_REGS(NUM_REGS), .IR_ACCESS(IR_ACCESS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .update_dr(update_dr),
    .chain_sel(chain_sel), .reg_req(reg_req), .reg_addr(reg_addr)
);

// File: tb/scan_regport_tb.sv
module scan_regport_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ir_value = 4'h0;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo, reg_req, reg_wr;
    logic [4:0]  chain_sel;
    logic [6:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    logic [31:0] mem [NREG];
    logic [39:0] expq [$];
    logic [31:0] exp_hold = '0;
    logic [4:0]  exp_chain = '0;
    int          total = 0, bad = 0, req_seen = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_regport u_dut (
        .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .chain_sel(chain_sel), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // register bank model; address 4 advances on every read
    assign reg_rdata = (reg_addr < 7'(NREG)) ? mem[reg_addr[3:0]] : 32'h0;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 32'h1000 + i;
            mem[4] <= 32'd100;
        end else if (reg_req) begin
            if (reg_wr) mem[reg_addr[3:0]] <= reg_wdata;
            else if (reg_addr == 7'd4) mem[4] <= mem[4] + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every request
    always @(negedge clk) begin
        if (rst_n && reg_req) begin
            req_seen++;
            if (expq.size() == 0) begin
                chk(0, "R5 unexpected request", {reg_wr, reg_addr, reg_wdata}, 40'h0);
            end else begin
                logic [39:0] e;
                e = expq.pop_front();
                if (e[39]) chk({reg_wr, reg_addr, reg_wdata} == e, "R3 write request", {reg_wr, reg_addr, reg_wdata}, e);
                else chk({reg_wr, reg_addr} == e[39:32], "R4 read request", {reg_wr, reg_addr, 32'h0}, {e[39:32], 32'h0});
            end
        end
    end

    // driver: one access frame; routed = frame reaches the register bank
    task automatic access(input logic [6:0] a, input bit dir, input logic [31:0] d, input bit routed);
        logic [39:0] fr, got;
        logic [31:0] nh;
        bit inr;
        fr = {dir, a, d};
        inr = (a < 7'(NREG));
        @(negedge clk) capture_dr = 1'b1;
        @(negedge clk) capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tdi = fr[i];
            got[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        nh = exp_hold;
        if (routed) begin
            chk(got[39:32] == 8'h0, "R2 address/direction capture zero", {32'h0, got[39:32]}, 40'h0);
            chk(got[31:0] == exp_hold, "R4 previous read result", {8'h0, got[31:0]}, {8'h0, exp_hold});
            if (inr) expq.push_back(dir ? fr : {dir, a, 32'h0});
            if (!dir) nh = inr ? mem[a[3:0]] : 32'h0;  // R6 out-of-range reads zero
        end else begin
            chk(got == 40'h0, "R8 tdo quiet when not routed", got, 40'h0);
        end
        update_dr = 1'b1;
        @(negedge clk) update_dr = 1'b0;
        repeat (3) @(negedge clk);
        exp_hold = nh;
    endtask

    task automatic chain_scan(input logic [4:0] v);
        logic [4:0] got;
        @(negedge clk) capture_dr = 1'b1;
        @(negedge clk) capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tdi = v[i];
            got[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge clk) update_dr = 1'b0;
        @(negedge clk);
        chk(got == exp_chain, "R7 capture returns current chain", {35'h0, got}, {35'h0, exp_chain});
        chk(chain_sel == v, "R7 update loads chain", {35'h0, chain_sel}, {35'h0, v});
        exp_chain = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(tdo == 1'b0 && reg_req == 1'b0, "R9 reset outputs", {38'h0, tdo, reg_req}, 40'h0);
        chk(chain_sel == 5'h0, "R9 reset chain", {35'h0, chain_sel}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);
        ir_value = 4'hC;
        // R1 R3 writes, then R4 pipelined reads
        access(7'd1, 1'b1, 32'hA5A5_0001, 1'b1);
        access(7'd2, 1'b1, 32'h5A5A_0002, 1'b1);
        access(7'd1, 1'b0, 32'h0, 1'b1);
        access(7'd2, 1'b0, 32'h0, 1'b1);
        access(7'd0, 1'b0, 32'h0, 1'b1);
        // R5 side-effect register read once per frame, dummy read of address 0
        access(7'd4, 1'b0, 32'h0, 1'b1);
        access(7'd0, 1'b0, 32'h0, 1'b1);
        access(7'd4, 1'b0, 32'h0, 1'b1);
        access(7'd0, 1'b0, 32'h0, 1'b1);
        chk(mem[4] == 32'd102, "R5 side effect count", {8'h0, mem[4]}, 40'd102);
        // R6 out of range: no request, reads zero
        access(7'd100, 1'b1, 32'hDEAD_BEEF, 1'b1);
        access(7'd9, 1'b0, 32'h0, 1'b1);
        access(7'd0, 1'b0, 32'h0, 1'b1);
        // R5 update without capture
        n = req_seen;
        @(negedge clk) update_dr = 1'b1;
        @(negedge clk) update_dr = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_seen == n, "R5 bare update issues nothing", 40'(req_seen), 40'(n));
        // R7 R8 chain select
        ir_value = 4'h2;
        chain_scan(5'd3);
        ir_value = 4'hC;
        n = req_seen;
        access(7'd3, 1'b1, 32'h1111_2222, 1'b0);
        chk(req_seen == n, "R8 nonzero chain blocks request", 40'(req_seen), 40'(n));
        ir_value = 4'h2;
        chain_scan(5'd0);
        ir_value = 4'hF;
        access(7'd3, 1'b1, 32'h3333_4444, 1'b0);
        chk(req_seen == n, "R8 other instruction blocks request", 40'(req_seen), 40'(n));
        chk(mem[3] == 32'h1003, "R8 register untouched", {8'h0, mem[3]}, 40'h1003);
        ir_value = 4'hC;
        access(7'd3, 1'b0, 32'h0, 1'b1);
        access(7'd0, 1'b0, 32'h0, 1'b1);
        chk(expq.size() == 0, "R5 all expected requests seen", 40'(expq.size()), 40'h0);
        finish_run();
    end
endmodule